// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Chain

This block lets several interrupt sources share a single request line to a processor. Each source sits in a cell. Cells are strung in a row, and the processor's acknowledge enters the row at cell 0. A source raises its local request with a one-cycle pulse. The cell keeps that request pending, and the shared request line to the processor is the OR of every pending cell.

When the processor raises acknowledge, the acknowledge walks down the row. A cell with nothing pending lets it through. The first pending cell keeps it and puts its configured vector number on the shared data bus. A cell nearer the processor therefore always wins. If no cell claims the acknowledge, the bus reads all ones, which marks a spurious interrupt. A small helper on the processor side turns the bus value into a handler-table byte address by multiplying it by four.

Each cell samples its request on the acknowledge's rising cycle. A request that arrives later in the same acknowledge cannot take it over. The winning cell drops its pending request in the cycle the processor lowers acknowledge, which is when the vector has been read.

Top module: `intr_vec_chain`

## Requirements
- R1: `cpu_irq` is high in exactly the cycles in which at least one cell holds a pending request.
- R2: Out of reset no cell is pending and all outputs are 0. A one-cycle pulse on `dev_req[i]` makes cell i pending from the next cycle on, and the cell stays pending until it is served.
- R3: In the cycle `cpu_iack` rises, `ack_grant` is combinationally the one-hot bit of the lowest-index pending cell. Bit i of `ack_grant` stands for cell i, and index 0 is nearest the processor.
- R4: A cell that is not pending passes the acknowledge on, and a cell that claims it blocks it. `chain_ack_out` is high only while `cpu_iack` is high and no cell claims. `ack_grant` never has more than one bit set.
- R5: While a cell holds the grant, `data_bus` equals that cell's vector, which is field i of `vec_cfg`, bits [i*VEC_W +: VEC_W].
- R6: While `cpu_iack` is high and no cell claims, `data_bus` is all ones (0xFF for 8-bit vectors).
- R7: For the rest of one acknowledge, the grant stays as it was decided on the rising cycle. A request that becomes pending after that cycle neither takes nor moves the grant.
- R8: The granted cell clears its pending request in the cycle `cpu_iack` falls. If a new request pulse for that same cell arrives in that cycle, the cell stays pending.
- R9: `vec_addr` always equals `data_bus` multiplied by 4.
- R10: While `cpu_iack` is low, `data_bus` is 0 and `ack_grant` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dev_req | input | N_DEV | Per-cell request pulse |
| vec_cfg | input | N_DEV*VEC_W | Per-cell vector numbers, cell i in field i |
| cpu_iack | input | 1 | Processor acknowledge into cell 0 |
| cpu_irq | output | 1 | Shared request line to the processor |
| ack_grant | output | N_DEV | One-hot claim of the acknowledge (bus drive enables) |
| chain_ack_out | output | 1 | Acknowledge leaving the last cell |
| data_bus | output | VEC_W | Vector, spurious code or 0 when idle |
| vec_addr | output | VEC_W+2 | Handler-table byte address |

## Verification
New requests and an acknowledge in progress can meet in the same cycle. The bench pulses a request on a cell above the current winner while acknowledge is held high, and checks each cycle that the grant and the bus still show the winner chosen on the rising cycle. A second collision happens at the falling edge, where a cell is cleared and gets a new pulse at once. The bench then raises acknowledge again and expects that same cell to win, which shows its pending request survived. A cycle-accurate model in the bench judges every output on every clock.

// File: rtl/intr_vec_pkg.sv
package intr_vec_pkg;
  localparam int unsigned ADDR_SHIFT = 2;  // table entries are 4 bytes
endpackage

// File: rtl/intr_chain_cell.sv
module intr_chain_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic req_set,
  input  logic ack_lvl,
  input  logic ack_rise,
  input  logic ack_in,
  output logic ack_out,
  output logic claim,
  output logic pend_o
);
  logic pend_q, pend_d;
  logic hold_q, hold_d;
  logic won_q, won_d;
  logic blk;

  // on the rising cycle the live request decides; afterwards the frozen copy
  assign blk     = ack_rise ? pend_q : hold_q;
  assign claim   = ack_in & blk;
  assign ack_out = ack_in & ~blk;
  assign pend_o  = pend_q;

  always_comb begin
    hold_d = hold_q;
    if (ack_rise) hold_d = pend_q;
    won_d = ack_lvl ? claim : 1'b0;
    pend_d = pend_q;
    if (req_set)               pend_d = 1'b1;
    else if (won_q && !ack_lvl) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hold_q <= 1'b0;
      won_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      hold_q <= hold_d;
      won_q  <= won_d;
    end
  end
endmodule

// File: rtl/intr_bus_merge.sv
module intr_bus_merge #(
  parameter int unsigned N_DEV = 4,
  parameter int unsigned VEC_W = 8
) (
  input  logic                   ack_lvl,
  input  logic [N_DEV-1:0]       grant,
  input  logic [N_DEV*VEC_W-1:0] vecs,
  output logic [VEC_W-1:0]       bus,
  output logic [VEC_W+1:0]       addr
);
  import intr_vec_pkg::*;
  localparam logic [VEC_W-1:0] SPURIOUS = '1;

  logic [VEC_W-1:0] ored;

  always_comb begin
    ored = '0;
    for (int i = 0; i < N_DEV; i++)
      if (grant[i]) ored = ored | vecs[i*VEC_W +: VEC_W];
    if (!ack_lvl)      bus = '0;
    else if (~|grant)  bus = SPURIOUS;
    else               bus = ored;
  end

  assign addr = {bus, {ADDR_SHIFT{1'b0}}};
endmodule

// File: rtl/intr_vec_chain.sv
module intr_vec_chain #(
  parameter int unsigned N_DEV = 4,
  parameter int unsigned VEC_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_DEV-1:0]       dev_req,
  input  logic [N_DEV*VEC_W-1:0] vec_cfg,
  input  logic                   cpu_iack,
  output logic                   cpu_irq,
  output logic [N_DEV-1:0]       ack_grant,
  output logic                   chain_ack_out,
  output logic [VEC_W-1:0]       data_bus,
  output logic [VEC_W+1:0]       vec_addr
);
  logic             iack_q;
  logic             iack_rise;
  logic [N_DEV:0]   ack_link;
  logic [N_DEV-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) iack_q <= 1'b0;
    else        iack_q <= cpu_iack;
  end

  assign iack_rise   = cpu_iack & ~iack_q;
  assign ack_link[0] = cpu_iack;

  for (genvar g = 0; g < N_DEV; g++) begin : g_cell
    intr_chain_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_set (dev_req[g]),
      .ack_lvl (cpu_iack),
      .ack_rise(iack_rise),
      .ack_in  (ack_link[g]),
      .ack_out (ack_link[g+1]),
      .claim   (ack_grant[g]),
      .pend_o  (pend[g])
    );
  end

  assign cpu_irq       = |pend;
  assign chain_ack_out = ack_link[N_DEV];

  intr_bus_merge #(.N_DEV(N_DEV), .VEC_W(VEC_W)) u_merge (
    .ack_lvl(cpu_iack),
    .grant  (ack_grant),
    .vecs   (vec_cfg),
    .bus    (data_bus),
    .addr   (vec_addr)
  );
endmodule

// File: rtl/intr_vec_chain_chk.sv
module intr_vec_chain_chk #(
  parameter int unsigned N_DEV = 4,
  parameter int unsigned VEC_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_DEV-1:0]       dev_req,
  input logic                   cpu_iack,
  input logic                   cpu_irq,
  input logic [N_DEV-1:0]       ack_grant,
  input logic                   chain_ack_out,
  input logic [VEC_W-1:0]       data_bus,
  input logic [VEC_W+1:0]       vec_addr
);
  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_grant));
  p_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_grant) |-> !chain_ack_out);
  p_req_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_req) |=> cpu_irq);
  p_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_iack && ack_grant == '0) |-> (data_bus == '1));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_iack |-> (data_bus == '0 && ack_grant == '0));
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_iack && $past(cpu_iack)) |-> $stable(ack_grant));
  p_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_addr[VEC_W+1:2] == data_bus && vec_addr[1:0] == 2'b00);
endmodule

bind intr_vec_chain intr_vec_chain_chk #(.N_DEV(N_DEV), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .cpu_iack(cpu_iack),
  .cpu_irq(cpu_irq), .ack_grant(ack_grant), .chain_ack_out(chain_ack_out),
  .data_bus(data_bus), .vec_addr(vec_addr)
);

// File: tb/test_intr_vec_chain.sv
module test_intr_vec_chain;
  localparam int N = 4;
  localparam int W = 8;

  logic           clk;
  logic           rst_n;
  logic [N-1:0]   dev_req;
  logic [N*W-1:0] vec_cfg;
  logic           cpu_iack;
  logic           cpu_irq;
  logic [N-1:0]   ack_grant;
  logic           chain_ack_out;
  logic [W-1:0]   data_bus;
  logic [W+1:0]   vec_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit [N-1:0] m_pend, m_hold, m_won;
  bit         m_prev;

  intr_vec_chain #(.N_DEV(N), .VEC_W(W)) i_intr_vec_chain (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .vec_cfg(vec_cfg),
    .cpu_iack(cpu_iack), .cpu_irq(cpu_irq), .ack_grant(ack_grant),
    .chain_ack_out(chain_ack_out), .data_bus(data_bus), .vec_addr(vec_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic [W-1:0] vec_of(int i);
    return W'(8'h30 + 8'(i * 7));
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock: drive inputs at negedge, compare outputs, advance model
  task automatic step(input [N-1:0] req, input bit ack);
    bit [N-1:0] claim;
    bit         a, rise, blk;
    logic [W-1:0] exp_bus;
    @(negedge clk);
    dev_req  = req;
    cpu_iack = ack;
    #1;
    rise = ack && !m_prev;
    a = ack;
    claim = '0;
    for (int i = 0; i < N; i++) begin
      blk = rise ? m_pend[i] : m_hold[i];
      claim[i] = a && blk;
      a = a && !blk;
    end
    exp_bus = '0;
    if (ack && claim == '0) exp_bus = '1;
    for (int i = 0; i < N; i++) if (claim[i]) exp_bus = vec_of(i);
    chk("R1 irq", cpu_irq, |m_pend);
    chk("R3 grant", ack_grant, claim);
    chk("R4 chain out", chain_ack_out, a);
    if (!ack)              chk("R10 idle bus", data_bus, exp_bus);
    else if (claim == '0)  chk("R6 spurious", data_bus, exp_bus);
    else                   chk("R5 vector", data_bus, exp_bus);
    chk("R9 addr", vec_addr, longint'(exp_bus) * 4);
    for (int i = 0; i < N; i++) begin
      m_won[i] = ack ? claim[i] : 1'b0;
      if (rise) m_hold[i] = m_pend[i];
      if (req[i])                       m_pend[i] = 1'b1;
      else if (m_won_prev(i) && !ack)   m_pend[i] = 1'b0;
    end
    m_won_q = m_won;
    m_prev = ack;
  endtask

  bit [N-1:0] m_won_q;
  function automatic bit m_won_prev(int i);
    return m_won_q[i];
  endfunction

  initial begin
    int seed;
    bit [N-1:0] r;
    for (int i = 0; i < N; i++) vec_cfg[i*W +: W] = vec_of(i);
    dev_req = '0; cpu_iack = 0; rst_n = 0;
    m_pend = '0; m_hold = '0; m_won = '0; m_won_q = '0; m_prev = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R2 reset irq", cpu_irq, 0);
    chk("R2 reset bus", data_bus, 0);
    chk("R2 reset grant", ack_grant, 0);
    // R6: acknowledge with nothing pending
    step('0, 1); step('0, 1); step('0, 0);
    // R2: request pulse sets pending, held
    step(4'b0100, 0); step('0, 0);
    chk("R2 pending held", cpu_irq, 1);
    // R7: later request on cell 0 during ack does not steal it
    step('0, 1);
    chk("R7 first grant", ack_grant, 4'b0100);
    step(4'b0001, 1); step('0, 1);
    chk("R7 grant kept", ack_grant, 4'b0100);
    step('0, 0);
    step('0, 1);
    chk("R7 later winner", ack_grant, 4'b0001);
    // R8: re-request in the falling cycle keeps the cell pending
    step(4'b0001, 0);
    step('0, 1);
    chk("R8 re-request kept", ack_grant, 4'b0001);
    step('0, 0); step('0, 0);
    chk("R8 cleared", cpu_irq, 0);
    // R3: several pending, served in chain order
    step(4'b1010, 0);
    for (int k = 0; k < 2; k++) begin
      step('0, 1);
      chk("R3 order", ack_grant, k == 0 ? 4'b0010 : 4'b1000);
      step('0, 0);
    end
    // mixed pattern
    seed = 32'h1d2c3b4a;
    for (int c = 0; c < 3000; c++) begin
      seed = seed * 1103515245 + 12345;
      r = '0;
      for (int i = 0; i < N; i++) r[i] = (((seed >>> (8 + i * 3)) & 7) == 0);
      step(r, ((seed >>> 20) & 3) != 0 && ((c / 5) % 2 == 1));
    end
    step('0, 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule